// File: doc/BRIEF.md
# Byte-Granular DMA Write Packer

This block sits between a pixel FIFO and a memory write bus. The FIFO supplies data as whole 32-bit words. A small stream of commands decides what happens to each byte of that data. A command can write a number of bytes starting at a given byte address. It can write a number of bytes continuing from where the last write ended. Or it can throw a number of bytes away.

The block keeps two positions. One is the byte offset inside the FIFO word at its head. The other is the current destination byte address. Bytes are moved one per cycle into an output word register, in the byte lane given by their destination address. That word goes to the bus as one aligned write, with only the lanes that were filled enabled. A word is sent when the destination reaches the end of a word or when the command's count runs out.

All three streams (command, FIFO, bus) use valid/ready:

- **Commands:** a command is taken only while the block is idle.
- **FIFO:** the block raises `fifo_ready` only in the cycle that uses the last byte of the head word, and only while `fifo_valid` is high.
- **Bus:** a write held on the bus keeps its address, data and enables unchanged until `bus_ready` is seen.

Top module: `dma_byte_packer`

## Requirements
- R1: After reset `cmd_ready` is 1, and `fifo_ready`, `bus_valid` and `cmd_done` are 0.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` stays 0 from acceptance until the command completes. Opcode encoding: 0 = write at address, 1 = continue write, 2 = skip (3 behaves as skip).
- R3: A write at address (opcode 0) sets the destination pointer to `cmd_addr` and stores `cmd_count` source bytes at consecutive byte addresses. Source bytes are taken in stream order, and within a FIFO word lane 0 (bits 7:0) comes first.
- R4: A continue write (opcode 1) ignores `cmd_addr` and starts at the byte after the last byte written by the previous write.
- R5: Every bus write has `bus_addr[1:0]` = 00 and a nonzero `bus_be`. Bit i of `bus_be` enables bits 8i+7:8i of the bus data. A command produces exactly one bus write per destination word it touches.
- R6: A one-byte write modifies only the addressed byte lane, with exactly one enable bit set.
- R7: A skip discards `cmd_count` source bytes and may start or end mid-word. The next command consumes the exact following source byte.
- R8: A FIFO word is popped only after all four of its bytes have been used by writes or skips. `fifo_ready` is never 1 while `fifo_valid` is 0.
- R9: While `bus_valid` is 1 and `bus_ready` is 0, on the next cycle `bus_valid` stays 1 and address, data and enables are unchanged. Gaps on `fifo_valid` only stall progress.
- R10: `cmd_done` pulses for one cycle as each command completes, and `cmd_ready` is 1 in that cycle.
- R11: A command with a zero count raises `cmd_done` in the cycle after acceptance, with no FIFO pop and no bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command may be taken |
| cmd_op | input | 2 | Opcode (0 write, 1 continue, 2 skip) |
| cmd_count | input | 12 | Byte count |
| cmd_addr | input | 32 | Destination byte address (opcode 0 only) |
| cmd_done | output | 1 | One-cycle completion pulse |
| fifo_valid | input | 1 | FIFO head word valid |
| fifo_ready | output | 1 | Pop the FIFO head word |
| fifo_data | input | 32 | FIFO head word |
| bus_valid | output | 1 | Bus write pending |
| bus_ready | input | 1 | Bus accepts the write |
| bus_addr | output | 32 | Word-aligned write address |
| bus_data | output | 32 | Write data |
| bus_be | output | 4 | Per-byte write enables |

## Verification
A zero-count command raises `cmd_done` one cycle after its acceptance edge. The bench checks for it at the first falling edge after that edge. Any other command finishes one cycle after its last byte is consumed (skip) or after its last bus write is accepted (write). This completion time depends on stalls, so the bench waits for the pulse and then compares the bus writes, memory bytes and FIFO pops against its own byte-level model. `cmd_ready` is sampled at the falling edge just after acceptance to confirm it has dropped.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_WRCONT = 2'd1,
    OP_SKIP   = 2'd2,
    OP_RSVD   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WR,
    ST_FLUSH,
    ST_SKIP
  } st_e;
endpackage

// File: rtl/dmap_src_tracker.sv
// Tracks the byte offset inside the FIFO head word and selects that byte.
module dmap_src_tracker #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              consume,
  input  logic [DATA_W-1:0] word,
  output logic [7:0]        sel_byte,
  output logic              last_lane
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [LANE_W-1:0] off;

  always_ff @(posedge clk) begin
    if (!rst_n)       off <= '0;
    else if (consume) off <= off + 1'b1;
  end

  assign sel_byte  = word[off*8 +: 8];
  assign last_lane = (off == LANE_W'(LANES - 1));
endmodule

// File: rtl/dmap_lane_acc.sv
// Output word register: steers a byte into its destination lane and tracks enables.
module dmap_lane_acc #(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(DATA_W/8)-1:0] lane,
  input  logic [7:0]                byte_in,
  input  logic                      clear,
  output logic [DATA_W-1:0]         data,
  output logic [DATA_W/8-1:0]       be
);
  localparam int LANES = DATA_W / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data[i*8 +: 8] <= '0;
        be[i]          <= 1'b0;
      end else if (wr_en && lane == i) begin
        data[i*8 +: 8] <= byte_in;
        be[i]          <= 1'b1;
      end else if (clear) begin
        be[i]          <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_byte_packer.sv
module dma_byte_packer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [1:0]          cmd_op,
  input  logic [CNT_W-1:0]    cmd_count,
  input  logic [ADDR_W-1:0]   cmd_addr,
  output logic                cmd_done,
  input  logic                fifo_valid,
  output logic                fifo_ready,
  input  logic [DATA_W-1:0]   fifo_data,
  output logic                bus_valid,
  input  logic                bus_ready,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W-1:0]   bus_data,
  output logic [DATA_W/8-1:0] bus_be
);
  import dmap_pkg::*;

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  st_e                  st;
  logic [ADDR_W-1:0]    dst;
  logic [ADDR_W-LANE_W-1:0] word_addr;
  logic [CNT_W-1:0]     cnt;
  logic                 consume, last_lane, acc_wr, acc_clr;
  logic [7:0]           src_byte;
  op_e                  op;

  assign op        = op_e'(cmd_op);
  assign consume   = (st == ST_WR || st == ST_SKIP) && fifo_valid;
  assign acc_wr    = (st == ST_WR) && fifo_valid;
  assign acc_clr   = (st == ST_FLUSH) && bus_ready;
  assign cmd_ready = (st == ST_IDLE);
  assign fifo_ready = consume && last_lane;
  assign bus_valid = (st == ST_FLUSH);
  assign bus_addr  = {word_addr, {LANE_W{1'b0}}};

  dmap_src_tracker #(.DATA_W(DATA_W)) u_src (
    .clk(clk), .rst_n(rst_n), .consume(consume), .word(fifo_data),
    .sel_byte(src_byte), .last_lane(last_lane)
  );

  dmap_lane_acc #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .wr_en(acc_wr), .lane(dst[LANE_W-1:0]),
    .byte_in(src_byte), .clear(acc_clr), .data(bus_data), .be(bus_be)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      dst       <= '0;
      word_addr <= '0;
      cnt       <= '0;
      cmd_done  <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      unique case (st)
        ST_IDLE: if (cmd_valid) begin
          cnt <= cmd_count;
          if (op == OP_WRITE) dst <= cmd_addr;
          if (cmd_count == '0)                          cmd_done <= 1'b1;
          else if (op == OP_WRITE || op == OP_WRCONT)   st <= ST_WR;
          else                                          st <= ST_SKIP;
        end
        ST_WR: if (fifo_valid) begin
          dst       <= dst + 1'b1;
          cnt       <= cnt - 1'b1;
          word_addr <= dst[ADDR_W-1:LANE_W];
          if (dst[LANE_W-1:0] == LANE_W'(LANES - 1) || cnt == CNT_W'(1))
            st <= ST_FLUSH;
        end
        ST_FLUSH: if (bus_ready) begin
          if (cnt == '0) begin
            st       <= ST_IDLE;
            cmd_done <= 1'b1;
          end else begin
            st <= ST_WR;
          end
        end
        ST_SKIP: if (fifo_valid) begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) begin
            st       <= ST_IDLE;
            cmd_done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmap_checker.sv
module dmap_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic [1:0]          cmd_op,
  input logic [CNT_W-1:0]    cmd_count,
  input logic [ADDR_W-1:0]   cmd_addr,
  input logic                cmd_done,
  input logic                fifo_valid,
  input logic                fifo_ready,
  input logic [DATA_W-1:0]   fifo_data,
  input logic                bus_valid,
  input logic                bus_ready,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_data,
  input logic [DATA_W/8-1:0] bus_be
);
  assert_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_addr[1:0] == 2'b00));

  assert_be_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_be != '0));

  assert_pop_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> fifo_valid);

  assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                   $stable(bus_data) && $stable(bus_be)));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> cmd_ready);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_count != '0) |=> !cmd_ready);

  assert_zero_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_count == '0) |=> (cmd_done && !bus_valid));
endmodule

bind dma_byte_packer dmap_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/dma_byte_packer_bench.sv
module dma_byte_packer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, cmd_ready, cmd_done;
  logic [1:0]  cmd_op = 0;
  logic [11:0] cmd_count = 0;
  logic [31:0] cmd_addr = 0;
  logic        fifo_valid, fifo_ready, bus_valid, bus_ready;
  logic [31:0] fifo_data, bus_addr, bus_data;
  logic [3:0]  bus_be;

  int checks = 0, failures = 0;
  int fidx = 0, wr_cnt = 0, done_cnt = 0, cyc = 0;
  int sptr = 0, dptr = 0;
  logic stall = 0;
  logic [7:0]  mem [64];
  logic [7:0]  exp_mem [64];
  logic [3:0]  last_be;
  logic [31:0] last_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] sb(int k);
    return 8'((k * 7 + 3) & 255);
  endfunction

  assign fifo_data  = {sb(4*fidx+3), sb(4*fidx+2), sb(4*fidx+1), sb(4*fidx)};
  assign fifo_valid = !stall || (cyc % 3 != 0);
  assign bus_ready  = !stall || (cyc % 4 == 3);

  dma_byte_packer u_dma_byte_packer (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fifo_valid && fifo_ready) fidx <= fidx + 1;
    if (cmd_done) done_cnt <= done_cnt + 1;
    if (bus_valid && bus_ready) begin
      wr_cnt    <= wr_cnt + 1;
      last_be   <= bus_be;
      last_addr <= bus_addr;
      for (int b = 0; b < 4; b++)
        if (bus_be[b]) mem[(int'(bus_addr[5:0]) + b) % 64] <= bus_data[8*b +: 8];
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) bad++;
    check(bad == 0, req, bad, 0);
    check(fidx == sptr / 4, {req, " R8 pops"}, fidx, sptr / 4);
  endtask

  // Issue one command, update the byte model, wait for completion.
  task automatic run(input logic [1:0] op, input int n, input int addr, output bit zero_ok);
    int d0 = done_cnt, t = 0;
    if (op == 2'd0) dptr = addr;
    if (op == 2'd2) sptr += n;
    else begin
      for (int i = 0; i < n; i++) exp_mem[dptr + i] = sb(sptr + i);
      sptr += n; dptr += n;
    end
    @(negedge clk);
    cmd_op = op; cmd_count = 12'(n); cmd_addr = 32'(addr); cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    zero_ok = cmd_done;
    if (n != 0) check(!cmd_ready, "R2 busy after accept", cmd_ready, 0);
    while (done_cnt == d0 && t < 4000) begin @(negedge clk); t++; end
    check(done_cnt == d0 + 1, "R10 done pulse", done_cnt - d0, 1);
  endtask

  task automatic t_reset();
    check(cmd_ready == 1, "R1 cmd_ready", cmd_ready, 1);
    check(fifo_ready == 0 && bus_valid == 0 && cmd_done == 0, "R1 idle outputs",
          {fifo_ready, bus_valid, cmd_done}, 0);
  endtask

  task automatic t_aligned();
    bit z; int w0 = wr_cnt;
    run(2'd0, 8, 'h10, z);
    check(wr_cnt - w0 == 2, "R5 writes per word", wr_cnt - w0, 2);
    check_mem("R3 aligned write");
  endtask

  task automatic t_single();
    bit z; int w0 = wr_cnt;
    run(2'd0, 1, 'h21, z);
    check(wr_cnt - w0 == 1, "R6 one write", wr_cnt - w0, 1);
    check(last_be == 4'b0010, "R6 lane enable", last_be, 4'b0010);
    check(last_addr == 32'h20, "R5 aligned addr", last_addr, 32'h20);
    check_mem("R6 single byte");
  endtask

  task automatic t_skip_rotate();
    bit z; int w0;
    run(2'd2, 3, 0, z);
    check_mem("R7 skip mid-word");
    w0 = wr_cnt;
    run(2'd0, 5, 'h2A, z);
    check(wr_cnt - w0 == 2, "R5 crossing writes", wr_cnt - w0, 2);
    check_mem("R7 resume after skip");
  endtask

  task automatic t_continue();
    bit z; int w0 = wr_cnt;
    run(2'd1, 6, 'h3F0, z);
    check(wr_cnt - w0 == 3, "R4 continue writes", wr_cnt - w0, 3);
    check_mem("R4 continue write");
  endtask

  task automatic t_zero();
    bit z; int w0 = wr_cnt, f0 = fidx;
    run(2'd0, 0, 'h3C, z);
    check(z == 1, "R11 done next cycle", z, 1);
    check(wr_cnt == w0 && fidx == f0, "R11 no pop/write", wr_cnt - w0 + fidx - f0, 0);
  endtask

  task automatic t_backpressure();
    bit z; int w0 = wr_cnt;
    stall = 1;
    run(2'd0, 7, 'h36, z);
    stall = 0;
    check(wr_cnt - w0 == 3, "R9 writes under stall", wr_cnt - w0, 3);
    check_mem("R9 data under stall");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = 8'hEE; exp_mem[i] = 8'hEE; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_aligned();
    t_single();
    t_skip_rotate();
    t_continue();
    t_zero();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule